// File: doc/BRIEF.md
# VGA Frame Capture Sampler

The sampler sits on the same clock as a pixel generator and watches its video output: horizontal sync, vertical sync and three 2-bit colour channels. It rebuilds the picture as a stream of memory writes, one pixel per clock, so that a framebuffer elsewhere on the chip fills with what a monitor would have shown.

Frame and line limits are not taken from a timing counter. The block follows the sync edges as they arrive. A frame is armed by a complete vertical sync pulse. Each line is armed by horizontal sync being low. A sync pulse that shows up in the middle of a line cuts that line or frame short.

Each 2-bit channel is scaled up to a full 8-bit byte. The pixel leaves as a 32-bit word holding red, green, blue and an opaque alpha byte, addressed by its byte offset in a packed frame. A one-cycle strobe marks the end of every frame.

Top module: `vga_frame_sampler`

## Requirements
- R1: After reset (active-low `rst_ni`), the block issues no write and no frame strobe until it has seen `vsync_i` high and then low. The line and column counts start at zero, so the first pixel of the first frame lands at address 0.
- R2: After the vertical arming pulse, the block waits for `hsync_i` low. Sampling starts on the clock after the one in which it sees `hsync_i` low. From then on, every clock with both syncs low gives exactly one write (`wr_valid_o` high), and the column advances by one.
- R3: If `hsync_i` is high during sampling, that clock gives no write, the line ends, and the next line begins at column 0 with the line index one higher.
- R4: If `vsync_i` is high during sampling, that clock gives no write, even when `hsync_i` is also high. `frame_done_o` is high in that same clock. The block then waits for `vsync_i` high and then low again, and the next frame begins at line 0.
- R5: A line holds at most 736 writes. The 736th write ends the line.
- R6: After a line ends, no further writes occur while `hsync_i` stays low. The next line starts only after `hsync_i` has been high and then low again.
- R7: A frame holds at most 520 lines. When line 520 ends, by either cause, `frame_done_o` is high in that clock and the block returns to waiting for the vertical arming pulse.
- R8: Each 2-bit colour value v is widened to the byte v×85, so 0, 1, 2 and 3 become 0, 85, 170 and 255.
- R9: `wr_data_o` carries red in bits 7:0, green in bits 15:8, blue in bits 23:16 and 0xFF in bits 31:24. It is valid in the same clock as the sampled inputs.
- R10: `wr_addr_o` equals (line × 736 + column) × 4, where line and column count from 0 within the frame.
- R11: `frame_done_o` is high for exactly one clock per frame end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock, shared with the generator |
| rst_ni | input | 1 | Asynchronous active-low reset |
| hsync_i | input | 1 | Observed horizontal sync |
| vsync_i | input | 1 | Observed vertical sync |
| red_i | input | 2 | Observed red level |
| green_i | input | 2 | Observed green level |
| blue_i | input | 2 | Observed blue level |
| wr_valid_o | output | 1 | Pixel write strobe |
| wr_addr_o | output | 21 | Byte address of the pixel word |
| wr_data_o | output | 32 | Packed RGBA pixel |
| frame_done_o | output | 1 | One-clock end-of-frame strobe |

## Verification
A line end and a frame end can fall in the same clock in two ways. Both syncs can rise together during sampling, and a line can end on line 520. The bench drives both syncs high in one clock during sampling and expects no write, a frame strobe and a return to vertical arming. It also runs a directed frame of 520 short lines and expects the strobe exactly on the last line's end. Random sync toggling adds further collisions, which a cycle-level bench model judges.

// File: rtl/vfs_pkg.sv
package vfs_pkg;
  typedef enum logic [2:0] {
    ST_WAIT_VS_HI,
    ST_WAIT_VS_LO,
    ST_WAIT_HS_LO,
    ST_SAMPLE,
    ST_WAIT_HS_HI
  } cap_state_e;
endpackage

// File: rtl/vfs_ctrl.sv
module vfs_ctrl
  import vfs_pkg::*;
#(
  parameter int LINE_PIX    = 736,
  parameter int FRAME_LINES = 520,
  localparam int COL_W = $clog2(LINE_PIX),
  localparam int ROW_W = $clog2(FRAME_LINES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hsync_i,
  input  logic             vsync_i,
  output logic             sample_o,
  output logic [COL_W-1:0] col_o,
  output logic [ROW_W-1:0] row_o,
  output logic             row_adv_o,
  output logic             frame_end_o
);
  localparam logic [COL_W-1:0] LAST_COL = COL_W'(LINE_PIX - 1);
  localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(FRAME_LINES - 1);

  cap_state_e state_q, state_d;
  logic [COL_W-1:0] col_q, col_d;
  logic [ROW_W-1:0] row_q, row_d;
  logic in_line, line_end;

  always_comb begin
    in_line     = (state_q == ST_SAMPLE);
    sample_o    = in_line && !vsync_i && !hsync_i;
    line_end    = in_line && !vsync_i && (hsync_i || col_q == LAST_COL);
    frame_end_o = (in_line && vsync_i) || (line_end && row_q == LAST_ROW);
    row_adv_o   = line_end && !frame_end_o;
  end

  always_comb begin
    state_d = state_q;
    col_d   = col_q;
    row_d   = row_q;
    unique case (state_q)
      ST_WAIT_VS_HI: if (vsync_i) state_d = ST_WAIT_VS_LO;
      ST_WAIT_VS_LO: if (!vsync_i) state_d = ST_WAIT_HS_LO;
      ST_WAIT_HS_LO: if (!hsync_i) state_d = ST_SAMPLE;
      ST_SAMPLE: begin
        if (frame_end_o) begin
          state_d = ST_WAIT_VS_HI;
          col_d   = '0;
          row_d   = '0;
        end else if (line_end) begin
          state_d = ST_WAIT_HS_HI;
          col_d   = '0;
          row_d   = row_q + 1'b1;
        end else if (sample_o) begin
          col_d = col_q + 1'b1;
        end
      end
      ST_WAIT_HS_HI: if (hsync_i) state_d = ST_WAIT_HS_LO;
      default: state_d = ST_WAIT_VS_HI;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_WAIT_VS_HI;
      col_q   <= '0;
      row_q   <= '0;
    end else begin
      state_q <= state_d;
      col_q   <= col_d;
      row_q   <= row_d;
    end
  end

  assign col_o = col_q;
  assign row_o = row_q;

  a_r5_col_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(col_q) < LINE_PIX);
  a_r7_row_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(row_q) < FRAME_LINES);
  a_r6_rearm_needs_hsync: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT_HS_HI && !hsync_i) |=> !sample_o);
endmodule

// File: rtl/vfs_addr_gen.sv
module vfs_addr_gen #(
  parameter int LINE_PIX    = 736,
  parameter int FRAME_LINES = 520,
  localparam int COL_W = $clog2(LINE_PIX),
  localparam int ROW_W = $clog2(FRAME_LINES),
  localparam int PIX_W = $clog2(LINE_PIX * FRAME_LINES),
  localparam int AW    = PIX_W + 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             row_adv_i,
  input  logic             frame_end_i,
  input  logic [COL_W-1:0] col_i,
  input  logic [ROW_W-1:0] row_i,
  output logic [AW-1:0]    addr_o
);
  // running line base avoids a row x LINE_PIX multiplier
  logic [PIX_W-1:0] base_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          base_q <= '0;
    else if (frame_end_i) base_q <= '0;
    else if (row_adv_i)   base_q <= base_q + PIX_W'(LINE_PIX);
  end

  assign addr_o = {base_q + PIX_W'(col_i), 2'b00};

  a_r10_base_tracks_row: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(base_q) == 32'(row_i) * LINE_PIX);
endmodule

// File: rtl/vfs_pixel_pack.sv
module vfs_pixel_pack #(
  parameter int CH_W = 2,
  localparam int SCALE = 255 / ((1 << CH_W) - 1)
) (
  input  logic [CH_W-1:0] red_i,
  input  logic [CH_W-1:0] green_i,
  input  logic [CH_W-1:0] blue_i,
  output logic [31:0]     data_o
);
  logic [CH_W-1:0] ch [3];
  assign ch[0] = red_i;
  assign ch[1] = green_i;
  assign ch[2] = blue_i;

  for (genvar i = 0; i < 3; i++) begin : g_ch
    assign data_o[8*i +: 8] = 8'(32'(ch[i]) * SCALE);
    always_comb begin
      if (ch[i] == '1) a_r8_full_scale: assert (data_o[8*i +: 8] == 8'hFF);
      if (ch[i] == '0) a_r8_zero_scale: assert (data_o[8*i +: 8] == 8'h00);
    end
  end

  assign data_o[31:24] = 8'hFF;
endmodule

// File: rtl/vga_frame_sampler.sv
module vga_frame_sampler #(
  parameter int LINE_PIX    = 736,
  parameter int FRAME_LINES = 520,
  parameter int CH_W        = 2,
  localparam int COL_W = $clog2(LINE_PIX),
  localparam int ROW_W = $clog2(FRAME_LINES),
  localparam int AW    = $clog2(LINE_PIX * FRAME_LINES) + 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            hsync_i,
  input  logic            vsync_i,
  input  logic [CH_W-1:0] red_i,
  input  logic [CH_W-1:0] green_i,
  input  logic [CH_W-1:0] blue_i,
  output logic            wr_valid_o,
  output logic [AW-1:0]   wr_addr_o,
  output logic [31:0]     wr_data_o,
  output logic            frame_done_o
);
  logic [COL_W-1:0] col;
  logic [ROW_W-1:0] row;
  logic row_adv, frame_end;

  vfs_ctrl #(.LINE_PIX(LINE_PIX), .FRAME_LINES(FRAME_LINES)) u_ctrl (
    .clk_i, .rst_ni, .hsync_i, .vsync_i,
    .sample_o(wr_valid_o), .col_o(col), .row_o(row),
    .row_adv_o(row_adv), .frame_end_o(frame_end)
  );

  vfs_addr_gen #(.LINE_PIX(LINE_PIX), .FRAME_LINES(FRAME_LINES)) u_addr (
    .clk_i, .rst_ni, .row_adv_i(row_adv), .frame_end_i(frame_end),
    .col_i(col), .row_i(row), .addr_o(wr_addr_o)
  );

  vfs_pixel_pack #(.CH_W(CH_W)) u_pack (
    .red_i, .green_i, .blue_i, .data_o(wr_data_o)
  );

  assign frame_done_o = frame_end;

  a_r5_addr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_o && $past(wr_valid_o)) |-> wr_addr_o == $past(wr_addr_o) + AW'(4));
  a_r11_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |=> !frame_done_o);
  a_r4_no_write_on_vsync: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vsync_i |-> !wr_valid_o);
  a_r3_no_write_on_hsync: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hsync_i |-> !wr_valid_o);
endmodule

// File: tb/tb_vga_frame_sampler.sv
module tb_vga_frame_sampler;
  localparam int LP = 736;
  localparam int FL = 520;

  logic clk = 0, rst_ni = 0;
  logic hs = 1, vs = 0;
  logic [1:0] rr = 0, gg = 0, bb = 0;
  logic wr_valid, done;
  logic [20:0] wr_addr;
  logic [31:0] wr_data;

  always #5 clk = ~clk;

  vga_frame_sampler dut (
    .clk_i(clk), .rst_ni(rst_ni), .hsync_i(hs), .vsync_i(vs),
    .red_i(rr), .green_i(gg), .blue_i(bb),
    .wr_valid_o(wr_valid), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .frame_done_o(done)
  );

  int checks = 0, errors = 0;
  string cur_req = "R1";
  int ph = 0, ln = 0, cl = 0;

  function automatic logic [31:0] exp_pix(logic [1:0] r, logic [1:0] g, logic [1:0] b);
    return {8'hFF, 8'(b * 85), 8'(g * 85), 8'(r * 85)};
  endfunction

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic cyc(bit h, bit v, logic [1:0] r, logic [1:0] g, logic [1:0] b);
    bit ev, ed, lend;
    @(negedge clk);
    hs = h; vs = v; rr = r; gg = g; bb = b;
    #2;
    ev   = (ph == 3) && !v && !h;
    lend = (ph == 3) && !v && (h || cl == LP - 1);
    ed   = ((ph == 3) && v) || (lend && ln == FL - 1);
    chk(cur_req, "wr_valid", wr_valid, ev);
    chk(ed ? "R7" : cur_req, "frame_done", done, ed);
    if (ev && wr_valid) begin
      chk("R10", "wr_addr", wr_addr, (ln * LP + cl) * 4);
      chk(cur_req == "R8" ? "R8" : "R9", "wr_data", wr_data, exp_pix(r, g, b));
    end
    @(posedge clk);
    case (ph)
      0: if (v) ph = 1;
      1: if (!v) ph = 2;
      2: if (!h) ph = 3;
      3: if (v) begin ph = 0; ln = 0; cl = 0; end
         else if (lend) begin
           if (ln == FL - 1) begin ph = 0; ln = 0; end
           else begin ph = 4; ln++; end
           cl = 0;
         end else cl++;
      4: if (h) ph = 2;
      default: ph = 0;
    endcase
  endtask

  task automatic cyc_rnd(bit h, bit v);
    cyc(h, v, 2'($urandom), 2'($urandom), 2'($urandom));
  endtask

  task automatic arm_frame();
    cyc_rnd(1, 1);
    cyc_rnd(1, 0);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    bit h, v;
    void'($urandom(32'd2718));
    repeat (3) @(posedge clk);
    @(negedge clk);
    #2;
    chk("R1", "reset wr_valid", wr_valid, 0);
    chk("R1", "reset frame_done", done, 0);
    rst_ni = 1;

    // R1: syncs low before arming: nothing
    cur_req = "R1";
    repeat (6) cyc_rnd(0, 0);
    cyc_rnd(1, 0);
    arm_frame();

    // R2: hsync low starts sampling one clock later
    cur_req = "R2";
    repeat (12) cyc_rnd(0, 0);
    // R3: hsync abort
    cur_req = "R3";
    cyc_rnd(1, 0);
    cyc_rnd(1, 0);
    cyc_rnd(0, 0);
    // R8: every colour combination
    cur_req = "R8";
    for (int i = 0; i < 64; i++) cyc(0, 0, 2'(i), 2'(i >> 2), 2'(i >> 4));
    // R5: run to the line cap
    cur_req = "R5";
    repeat (LP - 64 + 2) cyc_rnd(0, 0);
    // R6: hsync held low after line end
    cur_req = "R6";
    repeat (8) cyc_rnd(0, 0);
    cyc_rnd(1, 0);
    repeat (5) cyc_rnd(0, 0);
    // R4: both syncs rise together mid-line
    cur_req = "R4";
    cyc_rnd(1, 1);
    cur_req = "R11";
    cyc_rnd(0, 1);
    cyc_rnd(0, 0);
    cur_req = "R4";
    repeat (4) cyc_rnd(0, 0);
    arm_frame();
    repeat (5) cyc_rnd(0, 0);
    cyc_rnd(0, 1);
    cur_req = "R11";
    cyc_rnd(0, 1);
    cyc_rnd(0, 0);

    // R7: 520 short lines
    cur_req = "R7";
    arm_frame();
    for (int l = 0; l < FL; l++) begin
      cyc_rnd(0, 0);
      cyc_rnd(0, 0);
      cyc_rnd(1, 0);
      cyc_rnd(1, 0);
    end
    cur_req = "R11";
    repeat (4) cyc_rnd(0, 0);

    // R10: random sync activity
    cur_req = "R10";
    h = 1; v = 0;
    for (int n = 0; n < 40000; n++) begin
      if ($urandom % 40 == 0) h = !h;
      if ($urandom % 1500 == 0) v = !v;
      cyc_rnd(h, v);
    end

    summary();
    $finish;
  end
endmodule